// File: doc/BRIEF.md
# Interleaved Memory Time-Slot Arbiter

This block shares one memory bus between a CPU and a video fetch engine. Time is counted in CPU clock cycles and grouped into 4-cycle frames. Each frame holds two 2-cycle slots. The CPU slot serves a pending CPU request. The video slot issues a display fetch strobe, but only while Display Enable is high. A strap input chooses whether the CPU slots begin on cycles 0, 4, 8, … or on cycles 2, 6, 10, …, counted from reset. The second choice moves every video fetch two cycles later, which on screen is a two-pixel horizontal shift.

The block also keeps two copies of a 2-bit display mode value. The fast copy belongs to the timing generator and takes a write on any even cycle. The slow copy belongs to the video data path and changes only at the start of a CPU slot. It marks that change with a commit strobe. A write made at the start of a video slot therefore shows up in the fast copy two cycles before it reaches the slow copy. During those two cycles the copies may hold any pair of low, medium and high.

Top module: `membus_slot_arbiter`

## Requirements
- R1: While rst_n is low, and in cycle 0 (the first cycle after rst_n rises), cpu_gnt, vid_fetch and reg_commit are 0, and mode_fast and mode_slow both hold the low code. The mode codes are 2'b00 low, 2'b01 medium and 2'b10 high.
- R2: phase_sel is sampled only while rst_n is low. With 0, CPU slots start on cycles 0, 4, 8, …; with 1, they start on cycles 2, 6, 10, …. A change of phase_sel after reset has no effect on the slot timing.
- R3: cpu_req is sampled in the last cycle before each CPU slot. If it is high, cpu_gnt is high for both cycles of that slot, and otherwise it is low. cpu_gnt is never high outside a CPU slot.
- R4: A request raised at any other point is stalled and is first granted at the next CPU slot start. A request dropped after its grant produces exactly one 2-cycle grant.
- R5: vid_fetch is a one-cycle pulse in the first cycle of a video slot, issued only if de was high in the cycle before. With de low, the video slot stays idle.
- R6: With de held high, the fetch pulses fall on cycles 2, 6, 10, … for phase_sel 0 and on cycles 4, 8, 12, … for phase_sel 1, which is a shift of 2 cycles.
- R7: mode_wr and mode_data are sampled only on even cycles. An accepted write appears on mode_fast in the following cycle. A write on an odd cycle is ignored.
- R8: A write accepted in the first cycle of a CPU slot updates mode_slow in the same cycle as mode_fast. A write accepted in the first cycle of a video slot is held and reaches mode_slow two cycles after mode_fast. In the second cycle of every CPU slot the two copies are equal.
- R9: reg_commit is a one-cycle pulse in the cycle where mode_slow takes a committed value, which is always the second cycle of a CPU slot. With no write accepted, reg_commit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_sel | input | 1 | Slot phase strap, sampled during reset |
| cpu_req | input | 1 | CPU access request, level |
| de | input | 1 | Display Enable |
| mode_wr | input | 1 | Mode register write |
| mode_data | input | 2 | Mode write value |
| cpu_gnt | output | 1 | CPU owns the bus for this slot |
| vid_fetch | output | 1 | Video fetch strobe |
| reg_commit | output | 1 | Slow mode copy commit strobe |
| mode_fast | output | 2 | Timing-generator mode copy |
| mode_slow | output | 2 | Video-side mode copy |

## Verification
The CPU grant and the slow-copy commit can both fall in the second cycle of a CPU slot. A write accepted at the start of a CPU slot can also replace a value held from the video slot before it, at the same edge. The bench holds cpu_req high while it writes mode values in both video-slot and CPU-slot start cycles, with the two phase settings. Every cycle it compares the grant, the commit and both mode copies against a cycle model that follows the requirements.

// File: rtl/slot_arb_pkg.sv
// Package: shared constants for the interleaved memory slot arbiter.
// Assumes a 4-cycle frame made of two 2-cycle slots.
package slot_arb_pkg;
    localparam int FRAME_W = 2;               // bits of the cycle-in-frame counter
    localparam int MODE_W  = 2;               // width of the display mode value

    typedef enum logic [MODE_W-1:0] {
        RES_LOW  = 2'b00,
        RES_MED  = 2'b01,
        RES_HIGH = 2'b10
    } res_e;

    localparam logic [FRAME_W-1:0] LP_CPU0 = 2'd0;  // CPU slot, first cycle
    localparam logic [FRAME_W-1:0] LP_CPU1 = 2'd1;  // CPU slot, second cycle
    localparam logic [FRAME_W-1:0] LP_VID0 = 2'd2;  // video slot, first cycle
    localparam logic [FRAME_W-1:0] LP_VID1 = 2'd3;  // video slot, second cycle
endpackage

// File: rtl/slot_timer.sv
// Module: slot_timer
// Counts CPU cycles from reset and turns the count into a frame position
// (lphase) shifted by the phase strap. The strap gives an offset of 0 or 2
// cycles and is captured only while reset is held.
module slot_timer
    import slot_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_sel,
    output logic [FRAME_W-1:0] lphase,
    output logic               even_cyc
);
    logic [FRAME_W-1:0] cnt_q;
    logic [FRAME_W-1:0] off_q;

    // Free-running cycle counter, 0 in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Capture the phase offset while reset is held, then keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= phase_sel ? FRAME_W'(2) : FRAME_W'(0);
    end

    // Frame position relative to the selected slot phase.
    always_comb begin
        lphase   = cnt_q - off_q;
        even_cyc = ~cnt_q[0];
    end

    // R2: the offset never moves once reset is released.
    p_offset_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(off_q));
    // R2: the frame position advances by exactly one every cycle.
    p_frame_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lphase == FRAME_W'($past(lphase) + 1'b1)));
endmodule

// File: rtl/cpu_grant.sv
// Module: cpu_grant
// Samples the CPU request in the cycle before a CPU slot. If the request
// is high, it grants the bus for the whole 2-cycle slot.
// Assumes the requester holds cpu_req until it sees cpu_gnt.
module cpu_grant
    import slot_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] lphase,
    input  logic               cpu_req,
    output logic               cpu_gnt
);
    logic gnt_q;

    // Open the grant at the CPU slot start, close it when the slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gnt_q <= 1'b0;
        else if (lphase == LP_VID1) gnt_q <= cpu_req;
        else if (lphase == LP_CPU1) gnt_q <= 1'b0;
    end

    assign cpu_gnt = gnt_q;

    // R3: a grant lives only inside the CPU slot.
    p_gnt_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> (lphase == LP_CPU0 || lphase == LP_CPU1));
    // R3: a grant covers both cycles of its slot.
    p_gnt_full_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && lphase == LP_CPU0) |=> cpu_gnt);
    // R4: a grant starts only on a request sampled in the cycle before.
    p_gnt_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> $past(cpu_req));
endmodule

// File: rtl/video_fetch.sv
// Module: video_fetch
// Issues one fetch strobe at the start of each video slot when Display
// Enable was high in the cycle before. Otherwise the slot stays idle.
module video_fetch
    import slot_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] lphase,
    input  logic               de,
    output logic               vid_fetch
);
    logic fetch_q;

    // One-cycle strobe at the start of the video slot, gated by DE.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= 1'b0;
        else        fetch_q <= (lphase == LP_CPU1) && de;
    end

    assign vid_fetch = fetch_q;

    // R5: a strobe needs DE from the cycle before and the video slot start.
    p_fetch_needs_de_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vid_fetch |-> ($past(de) && lphase == LP_VID0));
    // R5: the strobe lasts exactly one cycle.
    p_fetch_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vid_fetch |=> !vid_fetch);
endmodule

// File: rtl/mode_copies.sv
// Module: mode_copies
// Holds the two copies of the display mode. The fast copy takes a write on
// any even cycle. The slow copy changes only at the CPU slot start: it
// takes a write made in that cycle, or else a write held from the video
// slot before. reg_commit marks the cycle where the slow copy changes.
module mode_copies
    import slot_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] lphase,
    input  logic               even_cyc,
    input  logic               mode_wr,
    input  logic [MODE_W-1:0]  mode_data,
    output logic [MODE_W-1:0]  mode_fast,
    output logic [MODE_W-1:0]  mode_slow,
    output logic               reg_commit
);
    logic [MODE_W-1:0] fast_q, slow_q, hold_d;
    logic              hold_v, commit_q;
    logic              wr_ok;

    // Writes count only on even cycles.
    assign wr_ok = mode_wr && even_cyc;

    // Fast copy: follows every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     fast_q <= RES_LOW;
        else if (wr_ok) fast_q <= mode_data;
    end

    // Slow copy: commits at the CPU slot start; video-slot writes wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q   <= RES_LOW;
            hold_d   <= RES_LOW;
            hold_v   <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (lphase == LP_CPU0) begin
                hold_v <= 1'b0;
                if (wr_ok) begin
                    slow_q   <= mode_data;
                    commit_q <= 1'b1;
                end else if (hold_v) begin
                    slow_q   <= hold_d;
                    commit_q <= 1'b1;
                end
            end else if (lphase == LP_VID0 && wr_ok) begin
                hold_d <= mode_data;
                hold_v <= 1'b1;
            end
        end
    end

    assign mode_fast  = fast_q;
    assign mode_slow  = slow_q;
    assign reg_commit = commit_q;

    // R7: the fast copy changes only after a write on an even cycle.
    p_fast_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_fast) |-> ($past(even_cyc) && $past(mode_wr)));
    // R9: the slow copy never changes without the commit strobe.
    p_slow_with_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_slow) |-> reg_commit);
    // R9: the commit strobe sits in the second cycle of a CPU slot.
    p_commit_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_commit |-> (lphase == LP_CPU1));
    // R8: the copies agree in the second cycle of every CPU slot.
    p_copies_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lphase == LP_CPU1) |-> (mode_fast == mode_slow));
endmodule

// File: rtl/membus_slot_arbiter.sv
// Module: membus_slot_arbiter (top)
// Splits a shared memory bus into alternating 2-cycle CPU and video slots
// and keeps the fast and slow copies of the display mode.
// Assumes a single clock and a synchronous active-low reset.
module membus_slot_arbiter
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_sel,
    input  logic              cpu_req,
    input  logic              de,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_data,
    output logic              cpu_gnt,
    output logic              vid_fetch,
    output logic              reg_commit,
    output logic [MODE_W-1:0] mode_fast,
    output logic [MODE_W-1:0] mode_slow
);
    logic [FRAME_W-1:0] lphase;
    logic               even_cyc;

    slot_timer i_timer (
        .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel),
        .lphase(lphase), .even_cyc(even_cyc)
    );

    cpu_grant i_grant (
        .clk(clk), .rst_n(rst_n), .lphase(lphase),
        .cpu_req(cpu_req), .cpu_gnt(cpu_gnt)
    );

    video_fetch i_fetch (
        .clk(clk), .rst_n(rst_n), .lphase(lphase),
        .de(de), .vid_fetch(vid_fetch)
    );

    mode_copies i_mode (
        .clk(clk), .rst_n(rst_n), .lphase(lphase), .even_cyc(even_cyc),
        .mode_wr(mode_wr), .mode_data(mode_data),
        .mode_fast(mode_fast), .mode_slow(mode_slow), .reg_commit(reg_commit)
    );

    // R3: the CPU and the video fetch never own the bus in the same cycle.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && vid_fetch));
endmodule

// File: tb/test_membus_slot_arbiter.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. A per-cycle model built from the
// requirements is compared with every output after each clock.
module test_membus_slot_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_sel = 1'b0, cpu_req = 1'b0, de = 1'b0, mode_wr = 1'b0;
    logic [1:0] mode_data = 2'b00;
    logic cpu_gnt, vid_fetch, reg_commit;
    logic [1:0] mode_fast, mode_slow;

    int n_chk = 0, n_bad = 0;
    int cyc;
    int off;
    logic e_gnt, e_fetch, e_commit, e_pend;
    logic [1:0] e_fast, e_slow, e_pd;

    always #10 clk = ~clk;

    membus_slot_arbiter i_membus_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel), .cpu_req(cpu_req),
        .de(de), .mode_wr(mode_wr), .mode_data(mode_data),
        .cpu_gnt(cpu_gnt), .vid_fetch(vid_fetch), .reg_commit(reg_commit),
        .mode_fast(mode_fast), .mode_slow(mode_slow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic int lp(input int k);
        return (k + 4 - off) % 4;
    endfunction

    // Reset with the given strap; ends in cycle 0.
    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; phase_sel = strap;
        cpu_req = 0; de = 0; mode_wr = 0; mode_data = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; off = strap ? 2 : 0;
        e_gnt = 0; e_fetch = 0; e_commit = 0; e_pend = 0;
        e_fast = 2'b00; e_slow = 2'b00; e_pd = 2'b00;
    endtask

    // Advance one cycle: model the next outputs, then compare them all.
    task automatic step();
        int p;
        logic wok;
        p = lp(cyc);
        wok = mode_wr && (cyc % 2 == 0);
        if (p == 3) e_gnt = cpu_req; else if (p == 1) e_gnt = 0;
        e_fetch = (p == 1) && de;
        e_commit = 0;
        if (p == 0) begin
            if (wok) begin e_slow = mode_data; e_commit = 1; end
            else if (e_pend) begin e_slow = e_pd; e_commit = 1; end
            e_pend = 0;
        end else if (p == 2 && wok) begin
            e_pend = 1; e_pd = mode_data;
        end
        if (wok) e_fast = mode_data;
        @(negedge clk);
        cyc++;
        chk("R3", cpu_gnt, e_gnt);
        chk("R5", vid_fetch, e_fetch);
        chk("R7", mode_fast, e_fast);
        chk("R8", mode_slow, e_slow);
        chk("R9", reg_commit, e_commit);
    endtask

    // R1: reset values, held during reset and in cycle 0.
    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 gnt", cpu_gnt, 0);
        chk("R1 fetch", vid_fetch, 0);
        chk("R1 commit", reg_commit, 0);
        chk("R1 fast", mode_fast, 0);
        chk("R1 slow", mode_slow, 0);
        do_reset(1'b1);
        chk("R1 gnt p1", cpu_gnt, 0);
        chk("R1 fetch p1", vid_fetch, 0);
    endtask

    // R2/R3/R4: a request in the middle of a frame, then the strap is flipped.
    task automatic t_grant(input logic strap);
        int first;
        do_reset(strap);
        phase_sel = ~strap;              // R2: ignored after reset
        step();
        cpu_req = 1;                     // raised in cycle 1
        first = -1;
        for (int i = 0; i < 14; i++) begin
            step();
            if (cpu_gnt && first < 0) begin
                first = cyc;
                cpu_req = 0;
            end
        end
        chk("R4 first grant cycle", first, strap ? 2 : 4);
        chk("R2 slot start", lp(first), 0);
    endtask

    // R5/R6: DE patterns; the first fetch cycle shows the strap shift.
    task automatic t_fetch(input logic strap);
        int first;
        do_reset(strap);
        de = 1;
        first = -1;
        for (int i = 0; i < 8; i++) begin
            step();
            if (vid_fetch && first < 0) first = cyc;
        end
        chk("R6 first fetch", first, strap ? 4 : 2);
        de = 0;                          // R5: idle slots while DE is low
        for (int i = 0; i < 8; i++) step();
        for (int i = 0; i < 12; i++) begin
            de = (i % 3 == 0);
            step();
        end
        chk("R5 idle end", vid_fetch, 0);
    endtask

    // R7/R8/R9: writes in CPU-slot, video-slot and odd cycles.
    task automatic t_mode(input logic strap);
        do_reset(strap);
        for (int i = 0; i < 24; i++) begin
            mode_wr = 1;
            mode_data = 2'(i % 3);
            if (i == 3 || i == 7) mode_data = 2'b10;
            if (i % 4 == 1) mode_wr = 0;  // some cycles without a write
            step();
            mode_wr = 0;
        end
        // Video-slot write then check the 2-cycle lag.
        while (lp(cyc) != 2) step();
        mode_wr = 1; mode_data = 2'b10;
        step(); mode_wr = 0;
        chk("R8 fast first", mode_fast, 2);
        chk("R8 slow lags", mode_slow != 2'b10, 1);
        step(); step();
        chk("R8 slow follows", mode_slow, 2);
        chk("R9 commit pulse", reg_commit, 1);
        // Odd-cycle write ignored.
        mode_wr = 1; mode_data = 2'b01;
        step(); mode_wr = 0;
        chk("R7 odd ignored", mode_fast, 2);
        for (int i = 0; i < 6; i++) step();
        chk("R9 no commit idle", reg_commit, 0);
    endtask

    // Grant and commit in the same CPU slot, with overriding writes.
    task automatic t_overlap(input logic strap);
        do_reset(strap);
        cpu_req = 1;
        for (int i = 0; i < 20; i++) begin
            mode_wr = (i % 2 == 0);
            mode_data = 2'((i / 2) % 3);
            step();
        end
        mode_wr = 0; cpu_req = 0;
        for (int i = 0; i < 4; i++) step();
    endtask

    initial begin : watchdog
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_grant(1'b0);
        t_grant(1'b1);
        t_fetch(1'b0);
        t_fetch(1'b1);
        t_mode(1'b0);
        t_mode(1'b1);
        t_overlap(1'b0);
        t_overlap(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule